// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the fetch address of a small 32-bit processor whose instructions are all one aligned word. Each cycle it looks at the instruction just fetched and at the two register operand values read for it. From these it picks the next fetch address. There are three candidates: the next sequential word, a PC-relative target for a branch-if-equal, and a pseudo-direct target for an unconditional jump.

The surrounding pipeline supplies the instruction word and the operand values. It can stall the unit with an enable input. The unit reports the current address, plus a registered flag that marks a cycle that follows a redirect. Instruction memory, the register file, the ALU and delay slots are outside this block.

Top module: `pcn_unit`

## Requirements
- R1: A synchronous active-high reset loads the address register with the parameter RESET_VEC, which must be word aligned, and clears the redirect flag.
- R2: While `en` is low the address holds its value, whatever the instruction, and the redirect flag reads 0 in the following cycle.
- R3: When the opcode (bits 31:26) is neither 2 nor 4, an enabled cycle advances the address by 4.
- R4: For opcode 4 (branch-if-equal) with equal `rs_val` and `rt_val`, the next address is the current address plus 4 plus the 16-bit field in bits 15:0, sign-extended and multiplied by 4.
- R5: For opcode 4 with unequal operand values, the branch is not taken and the next address is the current address plus 4.
- R6: For opcode 2 (jump), the next address is the top 4 bits of the current address, then bits 25:0 of the instruction, then two zero bits.
- R7: The branch offset covers the full signed range: 0x8000 moves back by 2^15 words from the sequential address, and 0x7FFF moves forward by 2^15-1 words.
- R8: `redirect` is 1 in the cycle after an enabled update that took a branch or a jump, and 0 in every other cycle.
- R9: The two low bits of the address are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Update enable; low stalls the address |
| instr | input | 32 | Instruction at the current address |
| rs_val | input | 32 | First register operand value |
| rt_val | input | 32 | Second register operand value |
| pc | output | 32 | Current fetch address |
| redirect | output | 1 | Previous enabled update was a taken branch or a jump |

## Verification
Plain non-control opcodes check the sequential path. Branch-if-equal is tried with equal and with unequal operands, which separates the compare from the opcode decode. Offsets of +3, 0x8000 and 0x7FFF separate correct sign extension and scaling from truncation or a missing shift. Jumps are issued from addresses whose top nibble is zero and from one where it is 0xF, which shows whether the upper PC bits are really kept. A stalled cycle that carries a jump word shows that the enable gates both the address and the flag.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned OFF_W   = 16;
    localparam int unsigned IDX_W   = 26;
    localparam int unsigned SEG_W   = 4;
    localparam int unsigned ALIGN_W = 2;
    localparam int unsigned EXT_W   = WORD_W - OFF_W - ALIGN_W;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;

    localparam logic [WORD_W-1:0] STEP = WORD_W'(1 << ALIGN_W);

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_JUMP   = 2'd2
    } nsel_e;

    typedef struct packed {
        logic [WORD_W-1:0] seq;
        logic [WORD_W-1:0] branch;
        logic [WORD_W-1:0] jump;
    } cand_t;

    function automatic logic [WORD_W-1:0] scale_off(input logic [OFF_W-1:0] off);
        return {{EXT_W{off[OFF_W-1]}}, off, {ALIGN_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] join_jump(input logic [SEG_W-1:0] seg,
                                                    input logic [IDX_W-1:0] idx);
        return {seg, idx, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pcn_decode.sv
module pcn_decode
    import pcn_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output nsel_e             sel
);
    logic is_beq;
    logic is_jump;
    logic ops_equal;

    assign is_beq    = (opc == OPC_BEQ);
    assign is_jump   = (opc == OPC_JUMP);
    assign ops_equal = (op_a == op_b);

    always_comb begin
        sel = SEL_SEQ;
        if (is_jump)
            sel = SEL_JUMP;
        else if (is_beq && ops_equal)
            sel = SEL_BRANCH;
    end
endmodule

// File: rtl/pcn_target.sv
module pcn_target
    import pcn_pkg::*;
(
    input  logic [WORD_W-1:0] cur_pc,
    input  logic [IDX_W-1:0]  idx,
    output cand_t             cand
);
    always_comb begin
        cand.seq    = cur_pc + STEP;
        cand.branch = cand.seq + scale_off(idx[OFF_W-1:0]);
        cand.jump   = join_jump(cur_pc[WORD_W-1 -: SEG_W], idx);
    end
endmodule

// File: rtl/pcn_unit.sv
module pcn_unit
    import pcn_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic        redirect
);
    nsel_e             sel;
    cand_t             cand;
    logic [WORD_W-1:0] next_pc;

    pcn_decode u_decode (
        .opc  (instr[WORD_W-1 -: OPC_W]),
        .op_a (rs_val),
        .op_b (rt_val),
        .sel  (sel)
    );

    pcn_target u_target (
        .cur_pc (pc),
        .idx    (instr[IDX_W-1:0]),
        .cand   (cand)
    );

    always_comb begin
        unique case (sel)
            SEL_BRANCH: next_pc = cand.branch;
            SEL_JUMP:   next_pc = cand.jump;
            default:    next_pc = cand.seq;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= RESET_VEC;
            redirect <= 1'b0;
        end else begin
            if (en)
                pc <= next_pc;
            redirect <= en && (sel != SEL_SEQ);
        end
    end
endmodule

// File: rtl/pcn_unit_chk.sv
module pcn_unit_chk #(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc,
    input logic        redirect
);
    logic [5:0] opc;
    assign opc = instr[31:26];

    p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == RESET_VEC && !redirect));

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pc == $past(pc) && !redirect));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && opc != 6'd2 && opc != 6'd4) |=> (pc == $past(pc) + 32'd4 && !redirect));

    p_beq_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (en && opc == 6'd4 && rs_val == rt_val) |=>
        (redirect && pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    p_beq_not_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (en && opc == 6'd4 && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4 && !redirect));

    p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
        (en && opc == 6'd2) |=> (redirect && pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    p_word_align_r9: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);
endmodule

bind pcn_unit pcn_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .pc       (pc),
    .redirect (redirect)
);

// File: tb/pcn_unit_bench.sv
module pcn_unit_bench;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] instr = 32'd0;
    logic [31:0] rs_val = 32'd0;
    logic [31:0] rt_val = 32'd0;
    logic [31:0] pc;
    logic        redirect;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_pc;

    pcn_unit #(.RESET_VEC(RV)) u_pcn_unit (
        .clk(clk), .rst(rst), .en(en), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .redirect(redirect)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mk_beq(input logic [15:0] off);
        return {6'd4, 5'd3, 5'd7, off};
    endfunction

    function automatic logic [31:0] mk_jump(input logic [25:0] idx);
        return {6'd2, idx};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        en = e; instr = ins; rs_val = a; rt_val = b;
        @(posedge clk);
        #1;
        check("R9", {30'd0, pc[1:0]}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        exp_pc = RV;
        check("R1", pc, exp_pc);
        check("R1", {31'd0, redirect}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sequential();
        step(1'b1, 32'h0123_4567, 32'd0, 32'd0);
        exp_pc = exp_pc + 32'd4;
        check("R3", pc, exp_pc);
        check("R8", {31'd0, redirect}, 32'd0);
        step(1'b1, {6'd35, 26'h3FF_FFFF}, 32'd1, 32'd1);
        exp_pc = exp_pc + 32'd4;
        check("R3", pc, exp_pc);
    endtask

    task automatic t_stall();
        step(1'b0, mk_jump(26'd77), 32'd0, 32'd0);
        check("R2", pc, exp_pc);
        check("R2", {31'd0, redirect}, 32'd0);
    endtask

    task automatic t_examples();
        step(1'b1, mk_jump(26'd20001), 32'd0, 32'd0);
        exp_pc = 32'd80004;
        check("R6", pc, exp_pc);
        check("R8", {31'd0, redirect}, 32'd1);
        step(1'b1, mk_beq(16'd3), 32'd9, 32'd9);
        exp_pc = 32'd80020;
        check("R4", pc, exp_pc);
        check("R8", {31'd0, redirect}, 32'd1);
        step(1'b1, mk_jump(26'd20004), 32'd0, 32'd0);
        step(1'b1, mk_jump(26'd20000), 32'd0, 32'd0);
        exp_pc = 32'd80000;
        check("R6", pc, exp_pc);
    endtask

    task automatic t_not_taken();
        step(1'b1, mk_beq(16'd3), 32'd9, 32'd8);
        exp_pc = 32'd80004;
        check("R5", pc, exp_pc);
        check("R8", {31'd0, redirect}, 32'd0);
    endtask

    task automatic t_neg_offset();
        step(1'b1, mk_beq(16'h8000), 32'hABCD, 32'hABCD);
        exp_pc = 32'd80008 - 32'd131072;
        check("R7", pc, exp_pc);
        check("R7", {28'd0, pc[31:28]}, 32'd15);
    endtask

    task automatic t_upper_jump();
        step(1'b1, mk_jump(26'd5), 32'd0, 32'd0);
        exp_pc = 32'hF000_0014;
        check("R6", pc, exp_pc);
    endtask

    task automatic t_pos_offset();
        step(1'b1, mk_beq(16'h7FFF), 32'd0, 32'd0);
        exp_pc = exp_pc + 32'd4 + 32'h0001_FFFC;
        check("R7", pc, exp_pc);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; instr = mk_jump(26'd9);
        @(posedge clk);
        #1;
        check("R1", pc, RV);
        check("R1", {31'd0, redirect}, 32'd0);
        @(negedge clk);
        rst = 1'b0; en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_stall();
        t_examples();
        t_not_taken();
        t_neg_offset();
        t_upper_jump();
        t_pos_offset();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule